// File: doc/BRIEF.md
# Codec control serial write master

This block lets on-chip logic program registers in one of two external audio codecs over a three-wire control link. The link has a serial data line, a serial clock and one active-low select per codec. A requester presents a chip index, a 5-bit register index and a data byte on a valid/ready stream input. The block packs these into a 16-bit write frame and shifts the frame out most significant bit first. A bit period is three equal steps, and each step lasts a configurable number of system clocks.

Back-pressure: `req_ready` is high only while the link is idle. A request is taken on any clock edge where `req_valid` and `req_ready` are both high. The requester keeps its fields stable until that edge. While `req_ready` is low, a held request waits and has no effect. A request whose chip index is out of range is consumed and then dropped. `frame_done` pulses for one clock when a frame has fully finished.

Top module: `cctl_serial_wr`

## Requirements
- R1: After reset, `ser_clk`, `ser_dat` and every bit of `ser_sel_n` are high, `req_ready` is high and `frame_done` is low.
- R2: The frame bits, in transmit order from first to last, are: 2'b10 (device identifier), then a constant 1 (write flag), then `req_addr[4:0]`, then `req_data[7:0]`.
- R3: During a frame, only `ser_sel_n[req_chip]` goes low, and the other select stays high for the whole frame.
- R4: The select falls STEP_CLKS clocks after the request is taken. The first fall of `ser_clk` comes exactly STEP_CLKS clocks after the select falls.
- R5: Each bit goes through three steps: `ser_clk` falls, then `ser_dat` takes the bit, then `ser_clk` rises. `ser_dat` never changes while `ser_clk` is high, except at the final return to idle.
- R6: Consecutive rising edges of `ser_clk` are exactly 3*STEP_CLKS system clocks apart, and a frame has exactly 16 rising edges.
- R7: One step after the 16th rising edge, all lines return high together. One step after that, `frame_done` is high for exactly one clock.
- R8: `req_ready` goes low on the clock after a valid request is taken and stays low until `frame_done`. A request held during that time is taken only after the frame ends and is sent intact.
- R9: A request with `req_chip` >= 2 is consumed without any bus activity. All lines stay high, `req_ready` stays high and `frame_done` does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_chip | input | 2 | Target codec index (0 or 1 valid) |
| req_addr | input | 5 | Codec register index |
| req_data | input | 8 | Byte to write |
| ser_clk | output | 1 | Serial clock, idles high; the receiver samples on its rising edge |
| ser_dat | output | 1 | Serial data, idles high |
| ser_sel_n | output | 2 | Active-low select, one per codec |
| frame_done | output | 1 | One-clock pulse at the end of each frame |

## Verification
The bench decodes the serial lines independently and rebuilds each frame from the rising clock edges. A wrong field order or bit order therefore shows up as a miscompare, and all-zero, all-one and alternating patterns expose stuck or swapped bits. It measures the gap between the select falling and the first clock fall, and between successive rising edges. A design that skipped the select lead-in or shortened a step would fail these timing checks. It also flags any data change while the clock is high; this catches a design that sets data on the rising edge. Finally it sends an out-of-range chip index, and a request held during a busy frame. A design that did not check the range would drive a select or pulse done. One that took a held request early would corrupt the frame in flight.

// File: rtl/cctl_pkg.sv
package cctl_pkg;
  localparam int CCTL_DEV_W  = 2;
  localparam logic [CCTL_DEV_W-1:0] CCTL_DEV_ID = 2'b10;
  localparam int CCTL_ADDR_W = 5;
  localparam int CCTL_DATA_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_SEL,
    PH_LOW,
    PH_SET,
    PH_HIGH,
    PH_TAIL
  } cctl_phase_e;
endpackage

// File: rtl/cctl_step_timer.sv
module cctl_step_timer #(
  parameter int STEP_CLKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic step_done
);
  localparam int CNT_W = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CLKS - 1);

  logic [CNT_W-1:0] cnt;

  assign step_done = run && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || step_done) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6: every step ends within STEP_CLKS clocks
  assert_step_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt) < STEP_CLKS));
endmodule

// File: rtl/cctl_frame_pack.sv
module cctl_frame_pack #(
  parameter int DEV_W  = 2,
  parameter logic [DEV_W-1:0] DEV_ID = 2'b10,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  localparam int FRAME_W = DEV_W + 1 + ADDR_W + DATA_W
) (
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_data,
  output logic [FRAME_W-1:0] frame
);
  // R2: device id, write flag, register index, data; sent from the top bit down
  assign frame = {DEV_ID, 1'b1, reg_addr, reg_data};
endmodule

// File: rtl/cctl_bit_engine.sv
module cctl_bit_engine
  import cctl_pkg::*;
#(
  parameter int FRAME_W   = 16,
  parameter int NUM_CHIPS = 2,
  parameter int CIDX_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [CIDX_W-1:0]    in_chip,
  input  logic [FRAME_W-1:0]   frame_in,
  output logic                 in_ready,
  input  logic                 step_done,
  output logic                 run,
  output logic                 sck,
  output logic                 sdo,
  output logic [NUM_CHIPS-1:0] cs_n,
  output logic                 done
);
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

  cctl_phase_e           ph;
  logic [FRAME_W-1:0]    shreg;
  logic [BIT_W-1:0]      bit_idx;
  logic [CIDX_W-1:0]     chip_q;
  logic [NUM_CHIPS-1:0]  sel_oh;
  logic                  chip_ok;
  logic                  accept;

  assign in_ready = (ph == PH_IDLE);
  assign run      = (ph != PH_IDLE);
  assign accept   = in_valid && in_ready;
  assign chip_ok  = ({1'b0, in_chip} < (CIDX_W + 1)'(NUM_CHIPS));

  for (genvar gi = 0; gi < NUM_CHIPS; gi++) begin : g_sel
    assign sel_oh[gi] = (chip_q == CIDX_W'(gi));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      shreg   <= '0;
      bit_idx <= '0;
      chip_q  <= '0;
      sck     <= 1'b1;
      sdo     <= 1'b1;
      cs_n    <= '1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (ph)
        PH_IDLE: begin
          if (accept && chip_ok) begin
            ph      <= PH_LEAD;
            shreg   <= frame_in;
            chip_q  <= in_chip;
            bit_idx <= '0;
          end
        end
        PH_LEAD: if (step_done) begin
          ph   <= PH_SEL;
          cs_n <= ~sel_oh;
        end
        PH_SEL: if (step_done) begin
          ph  <= PH_LOW;
          sck <= 1'b0;
        end
        PH_LOW: if (step_done) begin
          ph  <= PH_SET;
          sdo <= shreg[FRAME_W-1];
        end
        PH_SET: if (step_done) begin
          ph  <= PH_HIGH;
          sck <= 1'b1;
        end
        PH_HIGH: if (step_done) begin
          if (bit_idx == BIT_LAST) begin
            ph   <= PH_TAIL;
            sck  <= 1'b1;
            sdo  <= 1'b1;
            cs_n <= '1;
          end else begin
            ph      <= PH_LOW;
            sck     <= 1'b0;
            shreg   <= {shreg[FRAME_W-2:0], 1'b0};
            bit_idx <= bit_idx + 1'b1;
          end
        end
        PH_TAIL: if (step_done) begin
          ph   <= PH_IDLE;
          done <= 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assert_idle_lines_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (sck && sdo && (&cs_n)));

  assert_single_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~cs_n) <= 1));

  assert_data_moves_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo != $past(sdo)) |-> ((!sck && !$past(sck)) || (&cs_n)));

  assert_busy_after_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && chip_ok) |=> !in_ready);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_reject_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !chip_ok) |=> (in_ready && (&cs_n) && !done));
endmodule

// File: rtl/cctl_serial_wr.sv
module cctl_serial_wr
  import cctl_pkg::*;
#(
  parameter int STEP_CLKS = 20,
  parameter int NUM_CHIPS = 2,
  parameter int CIDX_W    = 2,
  parameter int ADDR_W    = CCTL_ADDR_W,
  parameter int DATA_W    = CCTL_DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [CIDX_W-1:0]    req_chip,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_data,
  output logic                 ser_clk,
  output logic                 ser_dat,
  output logic [NUM_CHIPS-1:0] ser_sel_n,
  output logic                 frame_done
);
  localparam int FRAME_W = CCTL_DEV_W + 1 + ADDR_W + DATA_W;

  logic [FRAME_W-1:0] frame;
  logic               run;
  logic               step_done;

  cctl_frame_pack #(
    .DEV_W (CCTL_DEV_W),
    .DEV_ID(CCTL_DEV_ID),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_pack (
    .reg_addr(req_addr),
    .reg_data(req_data),
    .frame   (frame)
  );

  cctl_step_timer #(
    .STEP_CLKS(STEP_CLKS)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .step_done(step_done)
  );

  cctl_bit_engine #(
    .FRAME_W  (FRAME_W),
    .NUM_CHIPS(NUM_CHIPS),
    .CIDX_W   (CIDX_W)
  ) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_chip  (req_chip),
    .frame_in (frame),
    .in_ready (req_ready),
    .step_done(step_done),
    .run      (run),
    .sck      (ser_clk),
    .sdo      (ser_dat),
    .cs_n     (ser_sel_n),
    .done     (frame_done)
  );
endmodule

// File: tb/sim_cctl_serial_wr.sv
`timescale 1ns/1ps
module sim_cctl_serial_wr;
  localparam int STEP = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_chip = '0;
  logic [4:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic       ser_clk, ser_dat, frame_done;
  logic [1:0] ser_sel_n;

  int nvec = 0;
  int nfail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cctl_serial_wr #(.STEP_CLKS(STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chip(req_chip), .req_addr(req_addr), .req_data(req_data),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_sel_n(ser_sel_n),
    .frame_done(frame_done)
  );

  // line monitor, sampled on the falling system clock edge
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [15:0] cap;
  int  nrise, last_rise, gap_bad, chg_bad, cs_time, first_fall;
  bit  sel0_seen, sel1_seen, cs_seen, fall_seen;
  logic sck_prev, sdo_prev;

  task automatic clear_mon();
    cap = '0; nrise = 0; last_rise = 0; gap_bad = 0; chg_bad = 0;
    cs_time = 0; first_fall = 0; sel0_seen = 0; sel1_seen = 0;
    cs_seen = 0; fall_seen = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (ser_clk && !sck_prev) begin
        cap = {cap[14:0], ser_dat};
        if (nrise > 0 && (cyc - last_rise) != 3*STEP) gap_bad++;
        nrise++;
        last_rise = cyc;
      end
      if (!ser_clk && sck_prev && !fall_seen) begin
        fall_seen = 1; first_fall = cyc;
      end
      if (!(&ser_sel_n) && !cs_seen) begin
        cs_seen = 1; cs_time = cyc;
      end
      if (!ser_sel_n[0]) sel0_seen = 1;
      if (!ser_sel_n[1]) sel1_seen = 1;
      if (ser_dat != sdo_prev && ser_clk && sck_prev && !(&ser_sel_n)) chg_bad++;
    end
    sck_prev = ser_clk;
    sdo_prev = ser_dat;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic take_request(input logic [1:0] c, input logic [4:0] a,
                              input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_chip = c; req_addr = a; req_data = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    int n = 0;
    seen = 0;
    while (!frame_done && n < 2000) begin @(negedge clk); n++; end
    seen = frame_done;
  endtask

  task automatic check_frame(input logic [1:0] c, input logic [4:0] a,
                             input logic [7:0] d, input string tag);
    logic [15:0] exp = {2'b10, 1'b1, a, d};
    bit seen;
    wait_done(seen);
    check(seen, "R7", {tag, " done pulse"}, seen, 1);
    check(cap == exp, "R2", {tag, " frame bits"}, cap, exp);
    check(nrise == 16, "R6", {tag, " rising edges"}, nrise, 16);
    check(gap_bad == 0, "R6", {tag, " bit period"}, gap_bad, 0);
    check(chg_bad == 0, "R5", {tag, " data moved while clock high"}, chg_bad, 0);
    check(sel0_seen == (c == 0) && sel1_seen == (c == 1), "R3",
          {tag, " select usage"}, {sel1_seen, sel0_seen}, (c == 0) ? 1 : 2);
    check(first_fall - cs_time == STEP, "R4", {tag, " select lead"},
          first_fall - cs_time, STEP);
    check(ser_clk && ser_dat && (&ser_sel_n) && req_ready, "R7",
          {tag, " idle at done"}, {req_ready, ser_sel_n, ser_dat, ser_clk}, 5'h1f);
    @(negedge clk);
    check(!frame_done, "R7", {tag, " done width"}, frame_done, 0);
  endtask

  task automatic run_frame(input logic [1:0] c, input logic [4:0] a,
                           input logic [7:0] d, input string tag);
    clear_mon();
    take_request(c, a, d);
    check(!req_ready, "R8", {tag, " ready dropped"}, req_ready, 0);
    check_frame(c, a, d, tag);
  endtask

  task automatic test_reset();
    check(ser_clk && ser_dat && (&ser_sel_n), "R1", "lines after reset",
          {ser_sel_n, ser_dat, ser_clk}, 4'hf);
    check(req_ready && !frame_done, "R1", "ready/done after reset",
          {req_ready, frame_done}, 2'b10);
  endtask

  task automatic test_reject();
    int bad = 0;
    int dn = 0;
    clear_mon();
    take_request(2'd2, 5'h0a, 8'h5a);
    for (int i = 0; i < 12*STEP; i++) begin
      if (!(ser_clk && ser_dat && (&ser_sel_n) && req_ready)) bad++;
      if (frame_done) dn++;
      @(negedge clk);
    end
    check(bad == 0, "R9", "chip 2 bus quiet", bad, 0);
    check(dn == 0, "R9", "chip 2 no done", dn, 0);
    clear_mon();
    take_request(2'd3, 5'h11, 8'h22);
    bad = 0;
    for (int i = 0; i < 12*STEP; i++) begin
      if (!(ser_clk && (&ser_sel_n) && req_ready)) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R9", "chip 3 bus quiet", bad, 0);
  endtask

  task automatic test_held_request();
    bit seen;
    int early = 0;
    clear_mon();
    take_request(2'd0, 5'h03, 8'hc3);
    // second request held while busy
    req_valid = 1'b1; req_chip = 2'd1; req_addr = 5'h1c; req_data = 8'h3c;
    wait_done(seen);
    if (!seen) early++;
    check(cap == {2'b10, 1'b1, 5'h03, 8'hc3}, "R8", "first frame intact under held req",
          cap, {2'b10, 1'b1, 5'h03, 8'hc3});
    check(!sel1_seen && seen, "R8", "held req not taken early", sel1_seen, 0);
    clear_mon();
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R8", "held req taken after done", req_ready, 0);
    check_frame(2'd1, 5'h1c, 8'h3c, "held");
    check(early == 0, "R8", "first done seen", early, 0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    sck_prev = 1'b1; sdo_prev = 1'b1;
    clear_mon();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run_frame(2'd0, 5'h15, 8'ha5, "chip0 pattern");
    run_frame(2'd1, 5'h0a, 8'h5a, "chip1 pattern");
    run_frame(2'd0, 5'h00, 8'h00, "zeros");
    run_frame(2'd1, 5'h1f, 8'hff, "ones");
    test_reject();
    run_frame(2'd1, 5'h01, 8'h80, "after reject");
    test_held_request();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule